// File: doc/BRIEF.md
# GPIO Special-Function Priority Multiplexer

This block decides, pin by pin, which function owns each pad of a small general-purpose port with six or ten pins. Each pin has its own fixed list of owners in priority order. The candidates are a debug interface (a data line and a clock line), a programmable clock output, a reference-clock input for a frequency counter, an LED driver, an oscillator enable, a programming-voltage flag and ordinary port I/O. For every pin the block produces a pad output-enable, a pad output value, the port read value, and the routing of the pad input to the function that owns it.

Ownership is decided in combinational logic from the control inputs. The one exception is the debug-activity flag. It arrives from another clock domain and passes through a two-flop synchroniser before it can take the debug pins away from the application. A package parameter selects the large variant (ten pins) or the small variant (six pins). In the small variant the four upper pins are tied off.

Top module: `gpio_prio_mux`

## Requirements
- R1: Pin 0 never drives its pad. While `prog_volt_i` or `osc_en_i` is 1, its read value is 0. Otherwise it reads `pad_in_i[0]`.
- R2: A pin held by its port role drives `pad_oe_o` equal to its `port_dir_i` bit (1 = output, 0 = input) and drives `pad_out_o` equal to `port_dir_i & port_out_i`. It returns `pad_in_i` on `port_rd_o`. Pins 1, 2, 7, 8 and 9 only ever have this role.
- R3: While `ref_en_i` is 1, pin 3 is not driven, its port read is 0, and `ref_clk_o` follows `pad_in_i[3]`. Otherwise `ref_clk_o` is 0.
- R4: While the synchronised debug flag is 1, pin 4 is owned by the debug data line: `pad_oe_o[4]` = `dbg_data_oe_i`, `dbg_data_in_o` = `pad_in_i[4]`, and the port read is 0. `dbg_data_in_o` is 0 at all other times.
- R5: When debug is idle, `clk_en_i` is 1 and `clk_sel_i[0]` is 1, pin 4 drives `clk_src_i` with output-enable 1, and its port read is 0.
- R6: While the synchronised debug flag is 1, pin 5 is an undriven input, `dbg_clk_in_o` follows `pad_in_i[5]`, and the port read is 0. This takes priority over the LED. `dbg_clk_in_o` is 0 at all other times.
- R7: When debug is idle and `led_mode_i` is not 0, the LED owns pin 5 and forces it to output. The drive value depends on `led_mode_i`: 01 drives 0, 10 drives 1, 11 drives `led_blink_i`. The port read is 0.
- R8: `led_status_o` equals the level driven on pin 5 while the LED owns the pin, and is 0 otherwise.
- R9: In the large variant, pin 6 drives `clk_src_i` when `clk_en_i` and `clk_sel_i[1]` are both 1. Otherwise pin 6 is a port pin.
- R10: With `LARGE_PKG` = 0, pins 6 to 9 have output-enable 0, output 0 and read value 0 for every input.
- R11: `dbg_active_i` takes effect on the second rising clock edge after it changes. Reset holds the synchronised flag at 0.
- R12: `pad_out_o` is 0 on every pin whose `pad_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the synchroniser |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_active_i | input | 1 | Debug transaction active (asynchronous) |
| dbg_data_oe_i | input | 1 | Debug data line output-enable |
| dbg_data_out_i | input | 1 | Debug data line output value |
| prog_volt_i | input | 1 | Programming voltage present on pin 0 |
| osc_en_i | input | 1 | Oscillator uses pin 0 |
| ref_en_i | input | 1 | Reference clock input enable on pin 3 |
| clk_en_i | input | 1 | Clock output enable |
| clk_sel_i | input | 2 | Clock output pin select (bit 0: pin 4, bit 1: pin 6) |
| clk_src_i | input | 1 | Clock to be driven out |
| led_mode_i | input | 2 | LED control on pin 5 (00 = not used) |
| led_blink_i | input | 1 | Blink pattern for LED mode 11 |
| port_dir_i | input | 10 | Port direction bits, 1 = output |
| port_out_i | input | 10 | Port output data |
| pad_in_i | input | 10 | Pad input levels |
| pad_oe_o | output | 10 | Pad output-enable |
| pad_out_o | output | 10 | Pad output value |
| port_rd_o | output | 10 | Port read value |
| ref_clk_o | output | 1 | Reference clock to the frequency counter |
| dbg_data_in_o | output | 1 | Debug data line input |
| dbg_clk_in_o | output | 1 | Debug clock input |
| led_status_o | output | 1 | LED drive state read-back |

## Verification
The hardest case to reach is pin 4 while another owner is also asking for it. The clock output holds the pin, and the debug flag rises partway through. The bench keeps the clock output and the LED requesting their pins and raises `dbg_active_i` at a falling edge. It checks after the first rising edge that the clock and LED still own their pins. After the second rising edge it checks that debug has taken both pins. It releases the flag in the same way and checks the handback edge by edge. Separately, the flag is held high during reset to show that ownership stays with the port.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int PAD_COUNT   = 10;
    localparam int SMALL_PINS  = 6;
    localparam int CLK_SEL_W   = 2;
    localparam int LED_MODE_W  = 2;

    localparam logic [LED_MODE_W-1:0] LED_UNUSED = 2'b00;
    localparam logic [LED_MODE_W-1:0] LED_DARK   = 2'b01;
    localparam logic [LED_MODE_W-1:0] LED_LIT    = 2'b10;
    localparam logic [LED_MODE_W-1:0] LED_PULSE  = 2'b11;

    typedef enum logic [3:0] {
        OWN_NONE    = 4'd0,
        OWN_PORT    = 4'd1,
        OWN_PORT_IN = 4'd2,
        OWN_VPP     = 4'd3,
        OWN_OSC     = 4'd4,
        OWN_REF     = 4'd5,
        OWN_DBG_DAT = 4'd6,
        OWN_DBG_CLK = 4'd7,
        OWN_CLKOUT  = 4'd8,
        OWN_LED     = 4'd9
    } owner_e;

    typedef struct packed {
        logic vpp_req;
        logic osc_req;
        logic ref_req;
        logic dbg_req;
        logic clk4_req;
        logic clk6_req;
        logic led_req;
        logic led_val;
        logic clk_src;
        logic dbg_oe;
        logic dbg_out;
    } role_req_t;

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

endpackage

// File: rtl/gpio_dbg_sync.sv
module gpio_dbg_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    import gpio_mux_pkg::*;

    sync_t stage_d, stage_q;

    always_comb begin
        stage_d    = stage_q;
        stage_d.s1 = async_i;
        stage_d.s2 = stage_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q.s2;

endmodule

// File: rtl/gpio_role_decode.sv
module gpio_role_decode
    import gpio_mux_pkg::*;
(
    input  logic                  dbg_sync_i,
    input  logic                  dbg_data_oe_i,
    input  logic                  dbg_data_out_i,
    input  logic                  prog_volt_i,
    input  logic                  osc_en_i,
    input  logic                  ref_en_i,
    input  logic                  clk_en_i,
    input  logic [CLK_SEL_W-1:0]  clk_sel_i,
    input  logic                  clk_src_i,
    input  logic [LED_MODE_W-1:0] led_mode_i,
    input  logic                  led_blink_i,
    output role_req_t             req_o
);

    always_comb begin
        req_o          = '0;
        req_o.vpp_req  = prog_volt_i;
        req_o.osc_req  = osc_en_i;
        req_o.ref_req  = ref_en_i;
        req_o.dbg_req  = dbg_sync_i;
        req_o.clk4_req = clk_en_i & clk_sel_i[0];
        req_o.clk6_req = clk_en_i & clk_sel_i[1];
        req_o.led_req  = (led_mode_i != LED_UNUSED);
        unique case (led_mode_i)
            LED_DARK:  req_o.led_val = 1'b0;
            LED_LIT:   req_o.led_val = 1'b1;
            LED_PULSE: req_o.led_val = led_blink_i;
            default:   req_o.led_val = 1'b0;
        endcase
        req_o.clk_src  = clk_src_i;
        req_o.dbg_oe   = dbg_data_oe_i;
        req_o.dbg_out  = dbg_data_out_i;
    end

endmodule

// File: rtl/gpio_pin_arb.sv
module gpio_pin_arb
    import gpio_mux_pkg::*;
#(
    parameter int PIN_IDX = 0,
    parameter bit PRESENT = 1'b1
) (
    input  role_req_t req_i,
    input  logic      dir_i,
    input  logic      pout_i,
    input  logic      pin_i,
    output owner_e    owner_o,
    output logic      oe_o,
    output logic      out_o,
    output logic      rd_o,
    output logic      fn_in_o
);

    owner_e owner;

    always_comb begin
        owner = OWN_PORT;
        if (!PRESENT) begin
            owner = OWN_NONE;
        end else begin
            case (PIN_IDX)
                0: begin
                    if (req_i.vpp_req)      owner = OWN_VPP;
                    else if (req_i.osc_req) owner = OWN_OSC;
                    else                    owner = OWN_PORT_IN;
                end
                3: owner = req_i.ref_req ? OWN_REF : OWN_PORT;
                4: begin
                    if (req_i.dbg_req)       owner = OWN_DBG_DAT;
                    else if (req_i.clk4_req) owner = OWN_CLKOUT;
                    else                     owner = OWN_PORT;
                end
                5: begin
                    if (req_i.dbg_req)      owner = OWN_DBG_CLK;
                    else if (req_i.led_req) owner = OWN_LED;
                    else                    owner = OWN_PORT;
                end
                6: owner = req_i.clk6_req ? OWN_CLKOUT : OWN_PORT;
                default: owner = OWN_PORT;
            endcase
        end
    end

    always_comb begin
        oe_o    = 1'b0;
        out_o   = 1'b0;
        rd_o    = 1'b0;
        fn_in_o = 1'b0;
        case (owner)
            OWN_PORT: begin
                oe_o  = dir_i;
                out_o = dir_i & pout_i;
                rd_o  = pin_i;
            end
            OWN_PORT_IN: rd_o = pin_i;
            OWN_REF, OWN_DBG_CLK: fn_in_o = pin_i;
            OWN_DBG_DAT: begin
                oe_o    = req_i.dbg_oe;
                out_o   = req_i.dbg_oe & req_i.dbg_out;
                fn_in_o = pin_i;
            end
            OWN_CLKOUT: begin
                oe_o  = 1'b1;
                out_o = req_i.clk_src;
            end
            OWN_LED: begin
                oe_o  = 1'b1;
                out_o = req_i.led_val;
            end
            default: ;
        endcase
    end

    assign owner_o = owner;

endmodule

// File: rtl/gpio_prio_mux.sv
module gpio_prio_mux
    import gpio_mux_pkg::*;
#(
    parameter bit LARGE_PKG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dbg_active_i,
    input  logic                  dbg_data_oe_i,
    input  logic                  dbg_data_out_i,
    input  logic                  prog_volt_i,
    input  logic                  osc_en_i,
    input  logic                  ref_en_i,
    input  logic                  clk_en_i,
    input  logic [CLK_SEL_W-1:0]  clk_sel_i,
    input  logic                  clk_src_i,
    input  logic [LED_MODE_W-1:0] led_mode_i,
    input  logic                  led_blink_i,
    input  logic [PAD_COUNT-1:0]  port_dir_i,
    input  logic [PAD_COUNT-1:0]  port_out_i,
    input  logic [PAD_COUNT-1:0]  pad_in_i,
    output logic [PAD_COUNT-1:0]  pad_oe_o,
    output logic [PAD_COUNT-1:0]  pad_out_o,
    output logic [PAD_COUNT-1:0]  port_rd_o,
    output logic                  ref_clk_o,
    output logic                  dbg_data_in_o,
    output logic                  dbg_clk_in_o,
    output logic                  led_status_o
);

    localparam int REF_PIN = 3;
    localparam int DAT_PIN = 4;
    localparam int LED_PIN = 5;

    logic                 dbg_sync;
    role_req_t            req;
    owner_e               owner [PAD_COUNT];
    logic [PAD_COUNT-1:0] fn_in;

    gpio_dbg_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (dbg_active_i),
        .sync_o  (dbg_sync)
    );

    gpio_role_decode u_decode (
        .dbg_sync_i     (dbg_sync),
        .dbg_data_oe_i  (dbg_data_oe_i),
        .dbg_data_out_i (dbg_data_out_i),
        .prog_volt_i    (prog_volt_i),
        .osc_en_i       (osc_en_i),
        .ref_en_i       (ref_en_i),
        .clk_en_i       (clk_en_i),
        .clk_sel_i      (clk_sel_i),
        .clk_src_i      (clk_src_i),
        .led_mode_i     (led_mode_i),
        .led_blink_i    (led_blink_i),
        .req_o          (req)
    );

    for (genvar p = 0; p < PAD_COUNT; p++) begin : g_pin
        gpio_pin_arb #(
            .PIN_IDX (p),
            .PRESENT (LARGE_PKG || (p < SMALL_PINS))
        ) u_arb (
            .req_i   (req),
            .dir_i   (port_dir_i[p]),
            .pout_i  (port_out_i[p]),
            .pin_i   (pad_in_i[p]),
            .owner_o (owner[p]),
            .oe_o    (pad_oe_o[p]),
            .out_o   (pad_out_o[p]),
            .rd_o    (port_rd_o[p]),
            .fn_in_o (fn_in[p])
        );
    end

    assign ref_clk_o     = fn_in[REF_PIN];
    assign dbg_data_in_o = fn_in[DAT_PIN];
    assign dbg_clk_in_o  = fn_in[LED_PIN];
    assign led_status_o  = (owner[LED_PIN] == OWN_LED) & pad_out_o[LED_PIN];

    AST_REF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_en_i |-> (!pad_oe_o[REF_PIN] && !port_rd_o[REF_PIN] && ref_clk_o == pad_in_i[REF_PIN])); // R3
    AST_DBG_DATA_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_sync |-> (pad_oe_o[DAT_PIN] == dbg_data_oe_i && !port_rd_o[DAT_PIN])); // R4
    AST_CLK_ON_PIN4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_sync && clk_en_i && clk_sel_i[0]) |-> (pad_oe_o[DAT_PIN] && pad_out_o[DAT_PIN] == clk_src_i)); // R5
    AST_DBG_CLK_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_sync |-> (!pad_oe_o[LED_PIN] && dbg_clk_in_o == pad_in_i[LED_PIN])); // R6
    AST_LED_FORCES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_sync && led_mode_i != LED_UNUSED) |-> pad_oe_o[LED_PIN]); // R7
    AST_PIN0_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_volt_i || osc_en_i) |-> (!pad_oe_o[0] && !port_rd_o[0])); // R1
    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out_o & ~pad_oe_o) == '0); // R12

endmodule

// File: tb/tb_gpio_prio_mux.sv
module tb_gpio_prio_mux;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dbg_active, dbg_oe, dbg_out, prog, osc, refen, clken, blink, csrc;
    logic [1:0] csel, led;
    logic [9:0] dir, pout, pin;
    logic [9:0] oe, out, rd, oe_s, out_s, rd_s;
    logic       refclk, dbg_din, dbg_cin, ledst;
    logic       refclk_s, dbg_din_s, dbg_cin_s, ledst_s;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_prio_mux #(.LARGE_PKG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .dbg_active_i(dbg_active), .dbg_data_oe_i(dbg_oe),
        .dbg_data_out_i(dbg_out), .prog_volt_i(prog), .osc_en_i(osc), .ref_en_i(refen),
        .clk_en_i(clken), .clk_sel_i(csel), .clk_src_i(csrc), .led_mode_i(led),
        .led_blink_i(blink), .port_dir_i(dir), .port_out_i(pout), .pad_in_i(pin),
        .pad_oe_o(oe), .pad_out_o(out), .port_rd_o(rd), .ref_clk_o(refclk),
        .dbg_data_in_o(dbg_din), .dbg_clk_in_o(dbg_cin), .led_status_o(ledst)
    );

    gpio_prio_mux #(.LARGE_PKG(1'b0)) dut_small (
        .clk(clk), .rst_n(rst_n), .dbg_active_i(dbg_active), .dbg_data_oe_i(dbg_oe),
        .dbg_data_out_i(dbg_out), .prog_volt_i(prog), .osc_en_i(osc), .ref_en_i(refen),
        .clk_en_i(clken), .clk_sel_i(csel), .clk_src_i(csrc), .led_mode_i(led),
        .led_blink_i(blink), .port_dir_i(dir), .port_out_i(pout), .pad_in_i(pin),
        .pad_oe_o(oe_s), .pad_out_o(out_s), .port_rd_o(rd_s), .ref_clk_o(refclk_s),
        .dbg_data_in_o(dbg_din_s), .dbg_clk_in_o(dbg_cin_s), .led_status_o(ledst_s)
    );

    typedef struct packed {
        logic       prog, osc, refen, clken;
        logic [1:0] csel, led;
        logic       blink, csrc;
        logic [9:0] dir, pout, pin;
        logic [9:0] e_oe, e_out, e_rd;
        logic       e_ref, e_led;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,10'h000,10'h000,10'h3FF,10'h000,10'h000,10'h3FF,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,10'h3FF,10'h2AA,10'h000,10'h3FE,10'h2AA,10'h000,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,1'b0,2'b00,2'b00,1'b0,1'b0,10'h000,10'h000,10'h3FF,10'h000,10'h000,10'h3F6,1'b1,1'b0},
        '{1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,10'h000,10'h000,10'h0F1,10'h000,10'h000,10'h0F0,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,2'b11,2'b00,1'b0,1'b1,10'h000,10'h000,10'h3FF,10'h050,10'h050,10'h3AF,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b1,2'b01,2'b00,1'b0,1'b0,10'h000,10'h000,10'h3FF,10'h010,10'h000,10'h3EF,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,1'b0,1'b1,10'h000,10'h000,10'h3FF,10'h000,10'h000,10'h3FF,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,2'b00,2'b01,1'b0,1'b0,10'h000,10'h000,10'h3FF,10'h020,10'h000,10'h3DF,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,2'b00,2'b10,1'b0,1'b0,10'h000,10'h000,10'h3FF,10'h020,10'h020,10'h3DF,1'b0,1'b1},
        '{1'b0,1'b0,1'b0,1'b0,2'b00,2'b11,1'b1,1'b0,10'h000,10'h000,10'h3FF,10'h020,10'h020,10'h3DF,1'b0,1'b1},
        '{1'b0,1'b0,1'b0,1'b0,2'b00,2'b11,1'b0,1'b0,10'h000,10'h000,10'h3FF,10'h020,10'h000,10'h3DF,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,10'h020,10'h020,10'h000,10'h020,10'h020,10'h000,1'b0,1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        dbg_active = 0; dbg_oe = 0; dbg_out = 0; prog = 0; osc = 0; refen = 0;
        clken = 0; csel = 0; csrc = 0; led = 0; blink = 0; dir = 0; pout = 0; pin = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        dbg_active = 1; pin = 10'h3FF; clken = 1; csel = 2'b01; csrc = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R11: reset holds the synchronised flag low, clock output keeps pin 4
        chk("R11 reset pin4 oe", oe[4], 1'b1);
        chk("R11 reset pin4 out", out[4], 1'b1);
        chk("R11 reset dbg_data_in", dbg_din, 1'b0);
        @(negedge clk); idle(); rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            prog = VEC[i].prog; osc = VEC[i].osc; refen = VEC[i].refen; clken = VEC[i].clken;
            csel = VEC[i].csel; led = VEC[i].led; blink = VEC[i].blink; csrc = VEC[i].csrc;
            dir = VEC[i].dir; pout = VEC[i].pout; pin = VEC[i].pin;
            #1;
            // R1 R2 R3 R5 R7 R8 R9 R12 vectors
            chk($sformatf("R2 vec%0d pad_oe", i), oe, VEC[i].e_oe);
            chk($sformatf("R12 vec%0d pad_out", i), out, VEC[i].e_out);
            chk($sformatf("R1 vec%0d port_rd", i), rd, VEC[i].e_rd);
            chk($sformatf("R3 vec%0d ref_clk", i), refclk, VEC[i].e_ref);
            chk($sformatf("R8 vec%0d led_status", i), ledst, VEC[i].e_led);
            @(negedge clk);
        end

        // R10: small variant ties off pins 6..9
        idle(); dir = 10'h3FF; pout = 10'h3FF; pin = 10'h3FF; clken = 1; csel = 2'b10; csrc = 1;
        #1;
        chk("R10 small oe", oe_s, 10'h03E);
        chk("R10 small out", out_s, 10'h03E);
        chk("R10 small rd", rd_s, 10'h03F);
        chk("R9 large pin6 clock", {oe[6], out[6], rd[6]}, 3'b110);

        // R4 R5 R6 R7 R11: debug takes pins 4 and 5 on the second edge
        @(negedge clk);
        idle(); pin = 10'h3FF; clken = 1; csel = 2'b01; csrc = 0; led = 2'b10;
        dbg_oe = 1; dbg_out = 1; dbg_active = 1;
        @(posedge clk); #1;
        chk("R11 one edge pin4 still clock", {oe[4], out[4]}, 2'b10);
        chk("R11 one edge pin5 still LED", {oe[5], out[5], ledst}, 3'b111);
        @(posedge clk); #1;
        chk("R4 debug data drives pin4", {oe[4], out[4], rd[4], dbg_din}, 4'b1101);
        chk("R6 debug clock pin5", {oe[5], out[5], rd[5], dbg_cin}, 4'b0001);
        chk("R8 led_status off under debug", ledst, 1'b0);
        @(negedge clk); dbg_oe = 0; pin = 10'h3EF; #1;
        chk("R4 debug release data oe", {oe[4], out[4], dbg_din}, 3'b000);
        dbg_active = 0;
        @(posedge clk); #1;
        chk("R11 one edge still debug", {oe[5], dbg_cin}, 2'b01);
        @(posedge clk); #1;
        chk("R5 clock back on pin4", {oe[4], out[4], dbg_din}, 3'b100);
        chk("R7 LED back on pin5", {oe[5], out[5], dbg_cin}, 3'b110);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule